// File: doc/BRIEF.md
# Circular Address Generation Unit

This block keeps four 12-bit address registers and turns them into memory addresses. A single shared adder/subtractor computes the next value of the selected register. The step can be plus one, minus one, plus an offset or minus an offset. The updated value is issued in one of two ways. In pre-modify it goes on the address bus. In post-modify the old value goes on the address bus. In both cases the new value is written back to the register.

A store operation drives the selected register's value onto a data output, so that the pointer itself can be saved to memory. A separate load port writes an immediate value into any register.

When circular mode is enabled, the register moves inside an aligned buffer of 2^k words. The low k bits step and wrap, and the upper bits stay fixed, so the pointer cycles through the buffer. The buffer base is the register value with its low k bits cleared. Address and data outputs are registered and appear one cycle after the operation.

Top module: `circ_agu`

## Requirements
- R1: A synchronous active-high reset clears all four address registers to zero and drops `addr_vld` and `data_vld`; these hold after the first clock edge with `rst` high.
- R2: With `ld_en` high, register `ld_sel` takes `ld_imm` at the clock edge.
- R3: `step` selects the modify amount: 0 is +1, 1 is -1, 2 is +`offset`, 3 is -`offset`. In linear mode the result wraps modulo 4096.
- R4: `op` = 1 (pre-modify) puts the updated value on `addr_out` with `addr_vld` high one cycle later. It also writes that value into register `sel`.
- R5: `op` = 2 (post-modify) puts the unmodified value on `addr_out` with `addr_vld` high one cycle later. It also writes the updated value into register `sel`.
- R6: `op` = 3 (store) puts the value of register `sel` on `data_out` with `data_vld` high one cycle later. `addr_vld` stays low and no register changes.
- R7: With `circ_en` high and `size_log2` = k < 12, the updated value keeps the upper 12-k bits of the old value. Its low k bits are (old + step) mod 2^k. For k >= 12 the result is the linear one.
- R8: When `ld_en` is high in the same cycle as a pre- or post-modify, only the load is written. The modify's write-back is dropped, but its address is still issued.
- R9: `op` = 0 (idle) raises no valid output and changes no register, whatever `step`, `offset` and `circ_en` hold.
- R10: A modify changes only register `sel`. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write `ld_imm` into register `ld_sel` |
| ld_sel | input | 2 | Register written by the load |
| ld_imm | input | 12 | Immediate value for the load |
| op | input | 2 | 0 idle, 1 pre-modify, 2 post-modify, 3 store |
| sel | input | 2 | Register used by `op` |
| step | input | 2 | 0 +1, 1 -1, 2 +offset, 3 -offset |
| offset | input | 12 | Offset for step codes 2 and 3 |
| circ_en | input | 1 | Enable circular wrapping |
| size_log2 | input | 4 | Buffer size exponent k (buffer of 2^k words) |
| addr_out | output | 12 | Memory address |
| addr_vld | output | 1 | `addr_out` valid |
| data_out | output | 12 | Register value for store-back |
| data_vld | output | 1 | `data_out` valid |

## Verification
Every result is due exactly one clock edge after the operation is presented. This holds for the address of a pre- or post-modify and for the data of a store. A register write is also visible to an operation presented in the very next cycle. The driver applies one operation per falling edge and queues the expected address and data for it. The monitor pops that entry shortly after the following rising edge, so each comparison lands in the single cycle where the result is due. Register contents that a modify, an idle cycle or a dropped write-back could have touched are read back through store operations on the following cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PRE   = 2'd1,
    OP_POST  = 2'd2,
    OP_STORE = 2'd3
  } agu_op_e;

  typedef enum logic [1:0] {
    ST_INC = 2'd0,
    ST_DEC = 2'd1,
    ST_ADD = 2'd2,
    ST_SUB = 2'd3
  } agu_step_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 12,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [AW-1:0]   wdata,
  input  logic [SELW-1:0] rsel,
  output logic [AW-1:0]   rdata
);
  logic [AW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && wsel == SELW'(g)) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata = regs[rsel];
endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int AW          = 12,
  parameter bit CIRC_SUPPORT = 1'b1,
  localparam int KW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] old_val,
  input  logic [1:0]    step,
  input  logic [AW-1:0] offset,
  input  logic          circ_en,
  input  logic [KW-1:0] size_log2,
  output logic [AW-1:0] new_val
);
  import agu_pkg::*;

  logic [AW-1:0] delta;
  logic [AW-1:0] sum;

  always_comb begin
    unique case (agu_step_e'(step))
      ST_INC:  delta = {{(AW-1){1'b0}}, 1'b1};
      ST_DEC:  delta = '1;
      ST_ADD:  delta = offset;
      default: delta = {AW{1'b0}} - offset;
    endcase
  end

  assign sum = old_val + delta;

  if (CIRC_SUPPORT) begin : g_circ
    logic [AW:0]   one_sh;
    logic [AW-1:0] mask;
    assign one_sh = {{AW{1'b0}}, 1'b1} << size_log2;
    always_comb begin
      if (size_log2 >= KW'(AW)) mask = '1;
      else                      mask = one_sh[AW-1:0] - {{(AW-1){1'b0}}, 1'b1};
    end
    assign new_val = circ_en ? ((old_val & ~mask) | (sum & mask)) : sum;
  end else begin : g_lin
    assign new_val = sum;
  end
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_vld_d,
  input  logic [AW-1:0] addr_d,
  input  logic          data_vld_d,
  input  logic [AW-1:0] data_d,
  output logic          addr_vld,
  output logic [AW-1:0] addr_out,
  output logic          data_vld,
  output logic [AW-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_vld <= 1'b0;
      data_vld <= 1'b0;
      addr_out <= '0;
      data_out <= '0;
    end else begin
      addr_vld <= addr_vld_d;
      data_vld <= data_vld_d;
      if (addr_vld_d) addr_out <= addr_d;
      if (data_vld_d) data_out <= data_d;
    end
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu #(
  parameter int AW           = 12,
  parameter int NREG         = 4,
  parameter bit CIRC_SUPPORT = 1'b1,
  localparam int SELW = $clog2(NREG),
  localparam int KW   = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic [AW-1:0]   ld_imm,
  input  logic [1:0]      op,
  input  logic [SELW-1:0] sel,
  input  logic [1:0]      step,
  input  logic [AW-1:0]   offset,
  input  logic            circ_en,
  input  logic [KW-1:0]   size_log2,
  output logic [AW-1:0]   addr_out,
  output logic            addr_vld,
  output logic [AW-1:0]   data_out,
  output logic            data_vld
);
  import agu_pkg::*;

  agu_op_e       op_e;
  logic          is_mod;
  logic [AW-1:0] rd_val;
  logic [AW-1:0] new_val;
  logic          wr_en;
  logic [SELW-1:0] wr_sel;
  logic [AW-1:0] wr_data;
  logic [AW-1:0] addr_d;

  assign op_e   = agu_op_e'(op);
  assign is_mod = (op_e == OP_PRE) || (op_e == OP_POST);

  // the load port wins; a modify write-back is dropped in that cycle
  assign wr_en   = ld_en | is_mod;
  assign wr_sel  = ld_en ? ld_sel : sel;
  assign wr_data = ld_en ? ld_imm : new_val;
  assign addr_d  = (op_e == OP_PRE) ? new_val : rd_val;

  agu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .wsel  (wr_sel),
    .wdata (wr_data),
    .rsel  (sel),
    .rdata (rd_val)
  );

  agu_step #(.AW(AW), .CIRC_SUPPORT(CIRC_SUPPORT)) u_step (
    .old_val   (rd_val),
    .step      (step),
    .offset    (offset),
    .circ_en   (circ_en),
    .size_log2 (size_log2),
    .new_val   (new_val)
  );

  agu_outreg #(.AW(AW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .addr_vld_d (is_mod),
    .addr_d     (addr_d),
    .data_vld_d (op_e == OP_STORE),
    .data_d     (rd_val),
    .addr_vld   (addr_vld),
    .addr_out   (addr_out),
    .data_vld   (data_vld),
    .data_out   (data_out)
  );
endmodule

// File: rtl/circ_agu_checker.sv
module circ_agu_checker #(
  parameter int AW = 12,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    op,
  input logic          circ_en,
  input logic [KW-1:0] size_log2,
  input logic [AW-1:0] rd_val,
  input logic [AW-1:0] addr_out,
  input logic          addr_vld,
  input logic [AW-1:0] data_out,
  input logic          data_vld
);
  logic [AW:0]   one_sh;
  logic [AW-1:0] mask_now;
  assign one_sh = {{AW{1'b0}}, 1'b1} << size_log2;
  always_comb begin
    if (size_log2 >= KW'(AW)) mask_now = '1;
    else                      mask_now = one_sh[AW-1:0] - {{(AW-1){1'b0}}, 1'b1};
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_val == '0 && !addr_vld && !data_vld));

  p_addr_issue_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 || op == 2'd2) |=> addr_vld && !data_vld);

  p_post_old_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd2) |=> addr_out == $past(rd_val));

  p_store_data_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd3) |=> (data_vld && !addr_vld && data_out == $past(rd_val)));

  p_circ_base_r7: assert property (@(posedge clk) disable iff (rst)
    (circ_en && (op == 2'd1 || op == 2'd2)) |=>
      (((addr_out ^ $past(rd_val)) & ~$past(mask_now)) == '0 || $past(op) == 2'd2));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd0) |=> (!addr_vld && !data_vld));

  p_valid_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_vld, data_vld}));
endmodule

bind circ_agu circ_agu_checker #(.AW(AW), .KW(KW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op        (op),
  .circ_en   (circ_en),
  .size_log2 (size_log2),
  .rd_val    (rd_val),
  .addr_out  (addr_out),
  .addr_vld  (addr_vld),
  .data_out  (data_out),
  .data_vld  (data_vld)
);

// File: tb/circ_agu_bench.sv
`timescale 1ns/1ps
module circ_agu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [11:0] ld_imm = '0;
  logic [1:0]  op = '0;
  logic [1:0]  sel = '0;
  logic [1:0]  step = '0;
  logic [11:0] offset = '0;
  logic        circ_en = 1'b0;
  logic [3:0]  size_log2 = '0;
  logic [11:0] addr_out, data_out;
  logic        addr_vld, data_vld;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  bit          q_av [$];
  logic [11:0] q_a  [$];
  bit          q_dv [$];
  logic [11:0] q_d  [$];
  string       q_tag[$];

  logic [11:0] mdl [4];

  always #10 clk = ~clk;

  circ_agu u_circ_agu (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_imm(ld_imm),
    .op(op), .sel(sel), .step(step), .offset(offset), .circ_en(circ_en),
    .size_log2(size_log2), .addr_out(addr_out), .addr_vld(addr_vld),
    .data_out(data_out), .data_vld(data_vld)
  );

  function automatic logic [11:0] next_val(input logic [11:0] old, input logic [1:0] st,
                                           input logic [11:0] off, input bit circ,
                                           input logic [3:0] k);
    logic [11:0] d, s, m;
    case (st)
      2'd0: d = 12'd1;
      2'd1: d = 12'hFFF;
      2'd2: d = off;
      default: d = 12'd0 - off;
    endcase
    s = old + d;
    if (circ && k < 4'd12) begin
      m = 12'((13'd1 << k) - 13'd1);
      return (old & ~m) | (s & m);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act,
                       input logic [11:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one operation per falling edge, expected result queued
  task automatic drive(input bit l, input logic [1:0] ls, input logic [11:0] li,
                       input logic [1:0] o, input logic [1:0] s, input logic [1:0] st,
                       input logic [11:0] off, input bit c, input logic [3:0] k,
                       input string tag);
    logic [11:0] old, nv;
    @(negedge clk);
    ld_en = l; ld_sel = ls; ld_imm = li; op = o; sel = s; step = st;
    offset = off; circ_en = c; size_log2 = k;
    old = mdl[s];
    nv  = next_val(old, st, off, c, k);
    q_av.push_back(o == 2'd1 || o == 2'd2);
    q_a.push_back(o == 2'd1 ? nv : old);
    q_dv.push_back(o == 2'd3);
    q_d.push_back(old);
    q_tag.push_back(tag);
    if ((o == 2'd1 || o == 2'd2) && !l) mdl[s] = nv;
    if (l) mdl[ls] = li;
  endtask

  task automatic idle();
    @(negedge clk);
    ld_en = 1'b0; op = 2'd0;
  endtask

  task automatic load(input logic [1:0] r, input logic [11:0] v, input string tag);
    drive(1'b1, r, v, 2'd0, 2'd0, 2'd0, 12'd0, 1'b0, 4'd0, tag);
  endtask

  task automatic store(input logic [1:0] r, input string tag);
    drive(1'b0, 2'd0, 12'd0, 2'd3, r, 2'd0, 12'd0, 1'b0, 4'd0, tag);
  endtask

  // monitor: pops one expected item just after the edge where it is due
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_tag.size() > 0) begin
        bit av, dv; logic [11:0] a, d; string t;
        av = q_av.pop_front(); a = q_a.pop_front();
        dv = q_dv.pop_front(); d = q_d.pop_front(); t = q_tag.pop_front();
        check(addr_vld == av, {t, " addr_vld"}, {11'd0, addr_vld}, {11'd0, av});
        check(data_vld == dv, {t, " data_vld"}, {11'd0, data_vld}, {11'd0, dv});
        if (av) check(addr_out == a, {t, " addr"}, addr_out, a);
        if (dv) check(data_out == d, {t, " data"}, data_out, d);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    check(!addr_vld && !data_vld, "R1 valids low in reset", {10'd0, addr_vld, data_vld}, 12'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) store(2'(i), "R1 reg cleared");

    load(2'd0, 12'h100, "R2 load r0");
    load(2'd1, 12'hFFF, "R2 load r1");
    load(2'd2, 12'h123, "R2 load r2");
    load(2'd3, 12'h80E, "R2 load r3");
    for (int i = 0; i < 4; i++) store(2'(i), "R2 loaded value");

    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd0, 2'd0, 12'd0, 1'b0, 4'd0, "R4 pre inc");
    drive(1'b0, 2'd0, 12'd0, 2'd2, 2'd0, 2'd1, 12'd0, 1'b0, 4'd0, "R5 post dec");
    store(2'd0, "R5 reg after post");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd1, 2'd0, 12'd0, 1'b0, 4'd0, "R3 wrap 4096");
    drive(1'b0, 2'd0, 12'd0, 2'd2, 2'd2, 2'd2, 12'h010, 1'b0, 4'd0, "R3 post add off");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd2, 2'd3, 12'h200, 1'b0, 4'd0, "R3 pre sub off");
    for (int i = 0; i < 4; i++) store(2'(i), "R10 only sel changed");

    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd3, 2'd0, 12'd0, 1'b1, 4'd4, "R7 circ inc");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd3, 2'd0, 12'd0, 1'b1, 4'd4, "R7 circ wrap to base");
    drive(1'b0, 2'd0, 12'd0, 2'd2, 2'd3, 2'd1, 12'd0, 1'b1, 4'd4, "R7 circ dec below base");
    store(2'd3, "R7 reg at buffer end");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd3, 2'd2, 12'h005, 1'b1, 4'd4, "R7 circ add off");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd1, 2'd1, 12'd0, 1'b1, 4'd12, "R7 k12 linear");
    drive(1'b0, 2'd0, 12'd0, 2'd1, 2'd2, 2'd0, 12'd0, 1'b1, 4'd0, "R7 k0 fixed");

    drive(1'b1, 2'd0, 12'h555, 2'd1, 2'd0, 2'd0, 12'd0, 1'b0, 4'd0, "R8 load and pre same reg");
    store(2'd0, "R8 load wins");
    drive(1'b1, 2'd1, 12'h0AA, 2'd2, 2'd2, 2'd0, 12'd0, 1'b0, 4'd0, "R8 load and post other reg");
    store(2'd1, "R8 loaded reg");
    store(2'd2, "R8 modify dropped");

    drive(1'b0, 2'd0, 12'd0, 2'd0, 2'd3, 2'd2, 12'h777, 1'b1, 4'd3, "R9 idle");
    store(2'd3, "R9 reg unchanged");

    idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    for (int i = 0; i < 4; i++) store(2'(i), "R1 cleared mid run");
    idle();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule